// File: doc/BRIEF.md
# Planar Frame Buffer Write Unit

This block forms the bytes that a processor store deposits into a frame buffer built from four bit planes. For every write it takes the processor byte, the four bytes currently held in the read latches, and a set of configuration values. From these it produces one result byte per plane and one write strobe per plane. The configuration values are a 2-bit write mode, a rotate count, a 4-bit set/reset color, a 4-bit set/reset enable, an 8-bit bit mask and a 4-bit plane enable.

Four write modes are provided:

- **Direct.** The processor byte is rotated, or a plane is forced to its set/reset color.
- **Latch copy.** Each plane is written with its own read latch.
- **Color expansion.** The low nibble of the processor byte is a pixel color, applied under the bit mask.
- **Masked set/reset.** The processor byte ANDed with the bit mask gates the set/reset color.

Results are registered. The strobes pulse for exactly one cycle per write, and the memory array beside the block uses them as byte write enables. The reset is asynchronous and active-low, and its release is synchronised inside the block. Writes presented during the two cycles after reset release are not taken.

Top module: `pfb_write_unit`

## Requirements
- R1: While reset is active, and after it is released until the first write, every plane_data byte is 0x00 and plane_we is 0000.
- R2: In mode 0 (wr_mode = 2'b00), with set/reset disabled for a plane, that plane receives wr_data rotated right by rot_amt (output bit i = wr_data[(i+rot_amt) mod 8]) at positions where bit_mask is 1. At positions where bit_mask is 0 it keeps its latch bit.
- R3: In mode 0, a plane whose sr_enable bit is 1 takes sr_color[plane] replicated to all eight bits instead of the rotated byte, still subject to bit_mask.
- R4: In mode 1 (wr_mode = 2'b01), every plane is written with its own latch byte, whatever wr_data and bit_mask hold.
- R5: In mode 2 (wr_mode = 2'b10), plane n receives wr_data[n] replicated to every position where bit_mask is 1, and its latch bit elsewhere.
- R6: In mode 3 (wr_mode = 2'b11), the per-bit mask is wr_data AND bit_mask (wr_data not rotated). Plane n receives sr_color[n] where that mask is 1 and its latch bit elsewhere.
- R7: A write sampled with wr_en = 1 on a rising edge sets plane_we to plane_en on the following cycle only. In any cycle after an edge with wr_en = 0, plane_we is 0000.
- R8: plane_data holds its last value across cycles with no write, whatever the other inputs do.
- R9: The plane index in packed buses is the byte index: plane n occupies bits [8n+7:8n] of latch_bytes and plane_data, and bit n of sr_color, sr_enable, plane_en and plane_we.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Processor write request, one cycle per write |
| wr_data | input | 8 | Processor write byte |
| latch_bytes | input | 32 | Read latch bytes, plane n at [8n+7:8n] |
| wr_mode | input | 2 | Write mode 0..3 |
| rot_amt | input | 3 | Right rotate count for mode 0 |
| sr_color | input | 4 | Set/reset color, bit n for plane n |
| sr_enable | input | 4 | Set/reset substitution enable for mode 0 |
| bit_mask | input | 8 | Per-bit write mask |
| plane_en | input | 4 | Per-plane write enable |
| plane_data | output | 32 | Registered result bytes, plane n at [8n+7:8n] |
| plane_we | output | 4 | Registered one-cycle plane write strobes |

## Verification
On every cycle the assertions check the following:

- Strobes follow the plane enables for exactly one cycle after a write and are otherwise zero.
- Result bytes hold between writes.
- Latch copy returns the latch bytes unchanged.
- In the masked modes, bit positions outside the effective mask keep their latch values.

The values written inside the mask can only be shown by the bench's scenarios. These are the rotation amounts, set/reset substitution per plane, color nibble expansion and the AND of data with mask in mode 3.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  typedef enum logic [1:0] {
    WM_DIRECT    = 2'd0,
    WM_LATCH     = 2'd1,
    WM_COLOR     = 2'd2,
    WM_MASKED_SR = 2'd3
  } wmode_e;
endpackage

// File: rtl/pfb_rst_sync.sv
module pfb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pfb_rotr.sv
module pfb_rotr #(
  parameter int W = 8,
  localparam int CW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [2*W-1:0] doubled;

  always_comb begin
    doubled = {din, din} >> amt;
    dout    = doubled[W-1:0];
  end
endmodule

// File: rtl/pfb_lane.sv
module pfb_lane
  import pfb_pkg::*;
#(
  parameter int W = 8
) (
  input  wmode_e       mode,
  input  logic [W-1:0] rot_byte,
  input  logic [W-1:0] cpu_byte,
  input  logic [W-1:0] latch_byte,
  input  logic [W-1:0] mask_byte,
  input  logic         sr_bit,
  input  logic         sr_en_bit,
  input  logic         color_bit,
  output logic [W-1:0] result
);
  logic [W-1:0] src;
  logic [W-1:0] msk;

  always_comb begin
    unique case (mode)
      WM_DIRECT: begin
        src = sr_en_bit ? {W{sr_bit}} : rot_byte;
        msk = mask_byte;
      end
      WM_LATCH: begin
        src = latch_byte;
        msk = '1;
      end
      WM_COLOR: begin
        src = {W{color_bit}};
        msk = mask_byte;
      end
      default: begin
        src = {W{sr_bit}};
        msk = cpu_byte & mask_byte;
      end
    endcase
    result = (src & msk) | (latch_byte & ~msk);
  end
endmodule

// File: rtl/pfb_write_unit.sv
module pfb_write_unit
  import pfb_pkg::*;
#(
  parameter int W       = 8,
  parameter int NPLANES = 4,
  localparam int CW     = $clog2(W),
  localparam int BUSW   = W * NPLANES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [W-1:0]       wr_data,
  input  logic [BUSW-1:0]    latch_bytes,
  input  logic [1:0]         wr_mode,
  input  logic [CW-1:0]      rot_amt,
  input  logic [NPLANES-1:0] sr_color,
  input  logic [NPLANES-1:0] sr_enable,
  input  logic [W-1:0]       bit_mask,
  input  logic [NPLANES-1:0] plane_en,
  output logic [BUSW-1:0]    plane_data,
  output logic [NPLANES-1:0] plane_we
);
  logic            rst_sync_n;
  logic [W-1:0]    rot_byte;
  logic [BUSW-1:0] lane_out;
  logic [BUSW-1:0] data_d, data_q;
  logic [NPLANES-1:0] we_d, we_q;
  wmode_e          mode;

  assign mode = wmode_e'(wr_mode);

  pfb_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pfb_rotr #(.W(W)) u_rotr (
    .din  (wr_data),
    .amt  (rot_amt),
    .dout (rot_byte)
  );

  for (genvar p = 0; p < NPLANES; p++) begin : g_lane
    pfb_lane #(.W(W)) u_lane (
      .mode       (mode),
      .rot_byte   (rot_byte),
      .cpu_byte   (wr_data),
      .latch_byte (latch_bytes[p*W +: W]),
      .mask_byte  (bit_mask),
      .sr_bit     (sr_color[p]),
      .sr_en_bit  (sr_enable[p]),
      .color_bit  (wr_data[p]),
      .result     (lane_out[p*W +: W])
    );
  end

  always_comb begin
    data_d = data_q;
    we_d   = '0;
    if (wr_en) begin
      data_d = lane_out;
      we_d   = plane_en;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      data_q <= '0;
      we_q   <= '0;
    end else begin
      if (wr_en) begin
        data_q <= data_d;
      end
      we_q <= we_d;
    end
  end

  assign plane_data = data_q;
  assign plane_we   = we_q;
endmodule

// File: rtl/pfb_write_checker.sv
module pfb_write_checker #(
  parameter int W       = 8,
  parameter int NPLANES = 4,
  localparam int BUSW   = W * NPLANES
) (
  input logic               clk,
  input logic               rst_ok,
  input logic               wr_en,
  input logic [W-1:0]       wr_data,
  input logic [1:0]         wr_mode,
  input logic [W-1:0]       bit_mask,
  input logic [BUSW-1:0]    latch_bytes,
  input logic [NPLANES-1:0] plane_en,
  input logic [BUSW-1:0]    plane_data,
  input logic [NPLANES-1:0] plane_we
);
  AST_STROBE_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_en |=> plane_we == $past(plane_en)); // R7
  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_ok)
    !wr_en |=> plane_we == '0); // R7
  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_ok)
    !wr_en |=> $stable(plane_data)); // R8
  AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && wr_mode == 2'd1) |=> plane_data == $past(latch_bytes)); // R4
  AST_DIRECT_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && wr_mode == 2'd0) |=>
      ((plane_data ^ $past(latch_bytes)) & ~{NPLANES{$past(bit_mask)}}) == '0); // R2
  AST_COLOR_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && wr_mode == 2'd2) |=>
      ((plane_data ^ $past(latch_bytes)) & ~{NPLANES{$past(bit_mask)}}) == '0); // R5
  AST_SR_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && wr_mode == 2'd3) |=>
      ((plane_data ^ $past(latch_bytes)) & ~{NPLANES{$past(wr_data & bit_mask)}}) == '0); // R6
endmodule

bind pfb_write_unit pfb_write_checker #(.W(W), .NPLANES(NPLANES)) u_chk (
  .clk         (clk),
  .rst_ok      (rst_sync_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .wr_mode     (wr_mode),
  .bit_mask    (bit_mask),
  .latch_bytes (latch_bytes),
  .plane_en    (plane_en),
  .plane_data  (plane_data),
  .plane_we    (plane_we)
);

// File: tb/pfb_write_unit_bench.sv
`timescale 1ns/1ps
module pfb_write_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic [31:0] latch_bytes;
  logic [1:0]  wr_mode;
  logic [2:0]  rot_amt;
  logic [3:0]  sr_color, sr_enable, plane_en;
  logic [7:0]  bit_mask;
  logic [31:0] plane_data;
  logic [3:0]  plane_we;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pfb_write_unit u_pfb_write_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .latch_bytes(latch_bytes), .wr_mode(wr_mode), .rot_amt(rot_amt),
    .sr_color(sr_color), .sr_enable(sr_enable), .bit_mask(bit_mask),
    .plane_en(plane_en), .plane_data(plane_data), .plane_we(plane_we)
  );

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected byte for one plane, written bit by bit from the requirements
  function automatic logic [7:0] model_plane(input int p, input logic [1:0] m,
      input logic [7:0] d, input logic [2:0] r, input logic [3:0] src,
      input logic [3:0] sre, input logic [7:0] bm, input logic [7:0] lat);
    logic [7:0] res;
    for (int i = 0; i < 8; i++) begin
      logic wbit, en;
      case (m)
        2'd0: begin
          wbit = sre[p] ? src[p] : d[(i + int'(r)) % 8];
          en   = bm[i];
        end
        2'd1: begin wbit = lat[i]; en = 1'b1; end
        2'd2: begin wbit = d[p]; en = bm[i]; end
        default: begin wbit = src[p]; en = d[i] & bm[i]; end
      endcase
      res[i] = en ? wbit : lat[i];
    end
    return res;
  endfunction

  // One write, then one idle cycle with scrambled inputs (R7, R8)
  task automatic do_write(input string req, input logic [1:0] m, input logic [7:0] d,
      input logic [2:0] r, input logic [3:0] src, input logic [3:0] sre,
      input logic [7:0] bm, input logic [3:0] pe, input logic [31:0] lat);
    logic [31:0] exp;
    for (int p = 0; p < 4; p++)
      exp[p*8 +: 8] = model_plane(p, m, d, r, src, sre, bm, lat[p*8 +: 8]);
    @(negedge clk);
    wr_en = 1'b1; wr_mode = m; wr_data = d; rot_amt = r; sr_color = src;
    sr_enable = sre; bit_mask = bm; plane_en = pe; latch_bytes = lat;
    @(posedge clk); #2;
    check32(req, plane_data, exp);
    check32({req, "/R7 strobe"}, {28'd0, plane_we}, {28'd0, pe});
    @(negedge clk);
    wr_en = 1'b0; wr_data = ~d; wr_mode = ~m; bit_mask = ~bm; latch_bytes = ~lat;
    plane_en = 4'hF;
    @(posedge clk); #2;
    check32("R7 idle strobe", {28'd0, plane_we}, 32'd0);
    check32("R8 hold", plane_data, exp);
  endtask

  localparam logic [31:0] LAT = 32'hC3_5A_0F_96; // plane3..plane0 (R9)

  task automatic t_reset;
    check32("R1 reset data", plane_data, 32'd0);
    check32("R1 reset strobe", {28'd0, plane_we}, 32'd0);
  endtask

  task automatic t_direct_rotate;
    do_write("R2 rot0", 2'd0, 8'hB4, 3'd0, 4'h0, 4'h0, 8'hFF, 4'hF, LAT);
    do_write("R2 rot3", 2'd0, 8'hB4, 3'd3, 4'h0, 4'h0, 8'hFF, 4'hF, LAT);
    do_write("R2 rot7", 2'd0, 8'h81, 3'd7, 4'h0, 4'h0, 8'hFF, 4'hF, LAT);
    do_write("R2 mask", 2'd0, 8'h3C, 3'd1, 4'h0, 4'h0, 8'h0F, 4'hF, LAT);
  endtask

  task automatic t_direct_sr;
    do_write("R3 sr", 2'd0, 8'h77, 3'd2, 4'b0001, 4'b0101, 8'hFF, 4'hF, LAT);
    do_write("R3 sr mask", 2'd0, 8'h00, 3'd0, 4'b1111, 4'b1100, 8'hF0, 4'hF, LAT);
  endtask

  task automatic t_latch;
    do_write("R4 latch", 2'd1, 8'hFF, 3'd5, 4'hF, 4'hF, 8'h00, 4'hF, 32'h12_34_56_78);
  endtask

  task automatic t_color;
    do_write("R5 color", 2'd2, 8'hA5, 3'd0, 4'h0, 4'h0, 8'h3C, 4'hF, LAT);
    do_write("R5 color full", 2'd2, 8'h0A, 3'd4, 4'h0, 4'hF, 8'hFF, 4'hF, LAT);
  endtask

  task automatic t_masked_sr;
    do_write("R6 msr", 2'd3, 8'hF0, 3'd3, 4'b1010, 4'h0, 8'h3C, 4'hF, LAT);
    do_write("R6 msr zero", 2'd3, 8'h0F, 3'd0, 4'b0110, 4'h0, 8'hF0, 4'hF, LAT);
  endtask

  task automatic t_plane_en;
    do_write("R7 en0110", 2'd0, 8'h5A, 3'd0, 4'h0, 4'h0, 8'hFF, 4'b0110, LAT);
    do_write("R9 en0001", 2'd2, 8'h01, 3'd0, 4'h0, 4'h0, 8'hFF, 4'b0001, 32'h00_00_00_00);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; latch_bytes = '0; wr_mode = '0;
    rot_amt = '0; sr_color = '0; sr_enable = '0; bit_mask = '0; plane_en = '0;
    repeat (3) @(posedge clk);
    #2 t_reset();
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2 t_reset();
    t_direct_rotate();
    t_direct_sr();
    t_latch();
    t_color();
    t_masked_sr();
    t_plane_en();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule